// File: doc/BRIEF.md
# Folded Third-Order Recursive Filter

This block computes the recursion y(n) = a·y(n-3) + b·y(n-5) + x(n) on 16-bit signed samples. The work of one sample takes four arithmetic operations: two products and two sums. These are spread over two clock cycles and run on one pipelined adder (one stage) and one pipelined multiplier (two stages). A parity bit, which toggles every clock, decides which operation each unit performs and which operands reach it. A new sample can be taken every second clock, and one result leaves every second clock.

Past outputs wait for reuse in three delay registers. They hold exactly the values that are still live: y(n-3) reaches the multiplier two cycles after it is produced, and y(n-5) reaches it five cycles after. A one-cycle skew register lines up the b-product with the a-product, so that the adder sees both at once. All arithmetic wraps modulo 2^16, and each product keeps its low 16 bits. The coefficients are treated as static.

The first clock after reset is released is an even (sample) slot. Slots then alternate even and odd. Each even slot is one step n of the recursion, whether or not a sample arrives in it.

Top module: `fold_iir3`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, out_valid is 0 and out_y is 0.
- R2: For slot n (the cycle 2n counted from the first cycle after reset), the result equals a·y(n-3) + b·y(n-5) + x(n), where y of a negative index is 0.
- R3: A strobe in the even cycle 2n gives out_valid high in cycle 2n+2, with y(n) on out_y in that same cycle.
- R4: in_valid and in_x in an odd cycle are ignored. They change neither out_valid nor any later result.
- R5: An even slot without a strobe counts as x(n)=0 and raises no out_valid. The recursion keeps running through such a slot, and any in_x value presented in it has no effect.
- R6: All sums and products wrap modulo 2^16 in two's complement. A product keeps the low 16 bits of its full value.
- R7: out_valid is high only in even cycles and is never high in two consecutive cycles.
- R8: Each stored past output moves one delay register further at every even-cycle edge. Each b-product is held for exactly one cycle to meet its a-product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe, used only in even cycles |
| in_x | input | 16 | Signed input sample |
| coef_a | input | 16 | Coefficient applied to y(n-3) |
| coef_b | input | 16 | Coefficient applied to y(n-5) |
| out_valid | output | 1 | Result strobe |
| out_y | output | 16 | Signed result, meaningful while out_valid is high |

## Verification
The hardest case to reach from the ports is a strobe that falls in the odd cycle. It lines up with the cycle in which the adder consumes the latched sample, so a fault there would corrupt the result quietly rather than raise an obvious error. The stimulus covers it by running the full vector table a second time while pulsing in_valid with a large sample in every odd cycle, and then comparing every result against the model that has no such pulses. Samples wrapping at the 16-bit boundary come from a directed impulse run whose expected values are worked out by hand.

// File: rtl/fold_iir3.sv
module fold_iir3 #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] coef_a,
  input  logic signed [W-1:0] coef_b,
  output logic                out_valid,
  output logic signed [W-1:0] out_y
);
  localparam int PW = 2 * W;

  logic                ph;
  logic signed [W-1:0] xq;
  logic signed [W-1:0] acc;
  logic signed [W-1:0] dly1, dly2, dly3;
  logic signed [W-1:0] mul_s1, mul_s2, skew;
  logic                v1, v2;

  logic signed [W-1:0]  mul_op, mul_cf;
  logic signed [PW-1:0] mul_full;

  assign mul_op   = ph ? dly3 : dly1;
  assign mul_cf   = ph ? coef_b : coef_a;
  assign mul_full = mul_op * mul_cf;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= 1'b0;
      xq     <= '0;
      acc    <= '0;
      dly1   <= '0;
      dly2   <= '0;
      dly3   <= '0;
      mul_s1 <= '0;
      mul_s2 <= '0;
      skew   <= '0;
      v1     <= 1'b0;
      v2     <= 1'b0;
    end else begin
      ph     <= ~ph;
      mul_s1 <= mul_full[W-1:0];
      mul_s2 <= mul_s1;
      v1     <= ~ph & in_valid;
      v2     <= v1;
      if (!ph) begin
        xq   <= in_valid ? in_x : '0;
        acc  <= mul_s2 + skew;
        dly1 <= acc;
        dly2 <= dly1;
        dly3 <= dly2;
      end else begin
        acc  <= acc + xq;
        skew <= mul_s2;
      end
    end
  end

  assign out_valid = v2;
  assign out_y     = acc;

  a_r7_even_only: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !ph);

  a_r7_no_repeat: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ph) |-> ##2 out_valid);

  a_r8_parity_toggle: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ph != $past(ph)));

  a_r8_shift: assert property (@(posedge clk) disable iff (rst)
    !ph |=> (dly2 == $past(dly1) && dly3 == $past(dly2)));

  a_r8_skew: assert property (@(posedge clk) disable iff (rst)
    ph |=> (skew == $past(mul_s2)));
endmodule

// File: tb/sim_fold_iir3.sv
module sim_fold_iir3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_x = '0;
  logic signed [15:0] coef_a = '0;
  logic signed [15:0] coef_b = '0;
  logic out_valid;
  logic signed [15:0] out_y;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fold_iir3 #(.W(16)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .coef_a(coef_a), .coef_b(coef_b), .out_valid(out_valid), .out_y(out_y)
  );

  localparam int NV = 24;
  localparam logic [16:0] VEC [0:NV-1] = '{
    17'h1_0005, 17'h1_FFFD, 17'h1_0010, 17'h0_1234, 17'h1_0100, 17'h1_7FFF,
    17'h1_8000, 17'h1_0001, 17'h0_ABCD, 17'h1_0000, 17'h1_FFFF, 17'h1_0042,
    17'h1_3000, 17'h1_D000, 17'h0_0000, 17'h1_0007, 17'h1_0ABC, 17'h1_F123,
    17'h1_0002, 17'h0_5555, 17'h1_0009, 17'h1_4000, 17'h1_C000, 17'h1_0011
  };

  logic        vs [0:63];
  logic [15:0] xs [0:63];
  logic [15:0] ym [0:63];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_model(input int n, input int a, input int b);
    for (int s = 0; s < n; s++) begin
      int y3, y5, xv, t;
      y3 = (s >= 3) ? int'($signed(ym[s-3])) : 0;
      y5 = (s >= 5) ? int'($signed(ym[s-5])) : 0;
      xv = vs[s] ? int'($signed(xs[s])) : 0;
      t = a * y3 + b * y5 + xv;
      ym[s] = t[15:0];
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    in_x = 16'sh7FFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(out_y == 16'sd0, "R1 data in reset", int'(out_y), 0);
    rst = 1'b0;
  endtask

  task automatic run(input int n, input int a, input int b, input bit inj_odd, input string tag);
    coef_a = 16'(a);
    coef_b = 16'(b);
    build_model(n, a, b);
    do_reset();
    for (int c = 0; c < 2 * n + 4; c++) begin
      bit ev;
      int s;
      ev = 1'b0;
      s = 0;
      if (c == 0) begin
        chk(out_valid == 1'b0 && out_y == 16'sd0, "R1 first cycle", int'(out_y), 0);
      end else if (c % 2 == 1) begin
        chk(out_valid == 1'b0, {"R7 odd cycle ", tag}, int'(out_valid), 0);
      end else if (c >= 2) begin
        s = (c - 2) / 2;
        ev = (s < n) ? vs[s] : 1'b0;
        chk(out_valid == ev, {"R3/R5 strobe ", tag}, int'(out_valid), int'(ev));
        if (ev)
          chk(out_y == ym[s], {"R2/R4/R6 value ", tag}, int'(out_y), int'($signed(ym[s])));
      end
      if (c % 2 == 0) begin
        s = c / 2;
        in_valid = (s < n) ? vs[s] : 1'b0;
        in_x = (s < n && vs[s]) ? xs[s] : 16'sh5A5A;
      end else begin
        in_valid = inj_odd;
        in_x = 16'sh7777;
      end
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      vs[i] = VEC[i][16];
      xs[i] = VEC[i][15:0];
    end
    run(NV, 3, -2, 1'b0, "table a=3 b=-2");
    run(NV, -1, 5, 1'b0, "table a=-1 b=5");
    run(NV, 3, -2, 1'b1, "R4 odd strobes");

    for (int i = 0; i < 16; i++) begin
      vs[i] = 1'b1;
      xs[i] = 16'h0000;
    end
    xs[0] = 16'h7FFF;
    xs[3] = 16'h0001;
    run(16, 1, 0, 1'b0, "R6 wrap");
    chk(ym[3] == 16'h8000, "R6 hand value y3", int'($signed(ym[3])), -32768);

    for (int i = 0; i < 16; i++) begin
      vs[i] = (i % 3 != 1);
      xs[i] = 16'h0000;
    end
    xs[0] = 16'h0004;
    run(16, 16384, 1, 1'b0, "R5 gaps impulse");
    chk(ym[3] == 16'h0000, "R6 product wrap y3", int'($signed(ym[3])), 0);
    chk(ym[5] == 16'h0004, "R2 b path y5", int'($signed(ym[5])), 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule